// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between an 8-bit CPU's 16-bit address bus and the memories and register files of a small handheld-style system. For every address it picks exactly one target region and drives a one-hot select for it. It also produces the physical offset of the access inside that target. It returns read data chosen from the per-region data lanes, and it raises a write strobe only when the target may actually be written.

The block owns one register: the switchable work-RAM bank number. A CPU write to I/O address 0xFF70 loads this register. It feeds the offset of every access to the switchable work-RAM window and to its mirror. The current video mode comes in as an input. It locks out video RAM and sprite attribute RAM while the video engine owns them. Writes aimed at cartridge ROM are never stored. Instead they leave the block as bank-controller commands.

Top module: `memmap_decoder`

## Requirements
- R1: `region_sel` is one-hot with bit indices 0 fixed ROM (0x0000–0x3FFF), 1 switchable ROM (0x4000–0x7FFF), 2 video RAM (0x8000–0x9FFF), 3 external RAM (0xA000–0xBFFF), 4 work RAM bank 0, 5 switchable work RAM, 6 sprite RAM, 7 unusable hole, 8 I/O, 9 high RAM, 10 interrupt enable.
- R2: 0xC000–0xCFFF and its mirror 0xE000–0xEFFF select bit 4; 0xD000–0xDFFF and its mirror 0xF000–0xFDFF select bit 5.
- R3: A write to 0xFF70 loads the bank register with the low 3 bits of `cpu_wdata`, where 0 is stored as 1. The new value appears on `wram_bank` from the next cycle. Reset leaves 1, and no other access changes the register.
- R4: While `video_mode` is 3, video RAM reads give 0xFF and video RAM writes give no `tgt_wr`.
- R5: Sprite RAM (0xFE00–0xFE9F) reads its lane and accepts writes only with `video_mode` 0 or 1. Otherwise it reads 0xFF and drops writes.
- R6: The hole 0xFEA0–0xFEFF always reads 0xFF and never raises `tgt_wr`.
- R7: 0xFF00–0xFF7F selects bit 8, 0xFF80–0xFFFE selects bit 9 and 0xFFFF selects bit 10.
- R8: A write in 0x0000–0x7FFF raises `cart_cmd_wr` and never `tgt_wr`. `cart_cmd_wr` is low for every other access.
- R9: With `xram_en` low, external RAM reads 0xFF and writes are dropped.
- R10: `phys_off` is addr[13:0] for both ROM regions, addr[12:0] for video and external RAM, addr[11:0] for bank 0, wram_bank·4096 + addr[11:0] for the switchable bank, addr[7:0] for sprite RAM and the hole, addr[6:0] for I/O and high RAM, and 0 for interrupt enable.
- R11: Outside the locked cases, `cpu_rdata` is byte lane `tgt_rdata[8*i+7:8*i]` of the selected region i, and `tgt_wr` follows `cpu_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write cycle |
| cpu_wdata | input | 8 | CPU write data |
| video_mode | input | 2 | Current video engine mode |
| xram_en | input | 1 | External RAM enabled by the bank controller |
| tgt_rdata | input | 88 | Read data lanes, one byte per region index |
| region_sel | output | 11 | One-hot target region |
| phys_off | output | 16 | Offset inside the target |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| tgt_wr | output | 1 | Write strobe to the selected target |
| cart_cmd_wr | output | 1 | Write forwarded as bank-controller command |
| wram_bank | output | 3 | Current switchable work-RAM bank |

## Verification
Region select, offset, read data and both write strobes are combinational in the address, mode and enable inputs. They are due in the same cycle the stimulus is applied. The bench drives each vector on the falling edge and compares the outputs just before the next rising edge. The bank register is the only registered result. A write to 0xFF70 changes `wram_bank` at that rising edge. The bench's own bank model is updated after the comparison, so the following vector checks the switchable-bank offsets against the new bank.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int N_REG   = 11;
  localparam int BANK_W  = 3;
  localparam int WBANK_SZ_LOG2 = 12;

  localparam int R_ROM0  = 0;
  localparam int R_ROMX  = 1;
  localparam int R_VRAM  = 2;
  localparam int R_XRAM  = 3;
  localparam int R_WRAM0 = 4;
  localparam int R_WRAMX = 5;
  localparam int R_OAM   = 6;
  localparam int R_HOLE  = 7;
  localparam int R_IO    = 8;
  localparam int R_HRAM  = 9;
  localparam int R_IE    = 10;

  localparam logic [ADDR_W-1:0] BANK_REG_ADDR = 16'hFF70;
  localparam logic [DATA_W-1:0] OPEN_BUS      = 8'hFF;
endpackage

// File: rtl/memmap_bank_reg.sv
module memmap_bank_reg
  import memmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  output logic [BANK_W-1:0] bank
);
  logic              rst_meta, rst_sync_n;
  logic [BANK_W-1:0] bank_nxt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    bank_nxt = wdata[BANK_W-1:0];
    if (bank_nxt == '0) bank_nxt = BANK_W'(1);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  bank <= BANK_W'(1);
    else if (load)    bank <= bank_nxt;
  end
endmodule

// File: rtl/memmap_region_dec.sv
module memmap_region_dec
  import memmap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  output logic [N_REG-1:0]  sel,
  output logic [ADDR_W-1:0] off
);
  localparam int IDX_W = $clog2(N_REG);
  logic [IDX_W-1:0] idx;

  always_comb begin
    unique case (addr[15:12])
      4'h0, 4'h1, 4'h2, 4'h3: idx = IDX_W'(R_ROM0);
      4'h4, 4'h5, 4'h6, 4'h7: idx = IDX_W'(R_ROMX);
      4'h8, 4'h9:             idx = IDX_W'(R_VRAM);
      4'hA, 4'hB:             idx = IDX_W'(R_XRAM);
      4'hC, 4'hE:             idx = IDX_W'(R_WRAM0);
      4'hD:                   idx = IDX_W'(R_WRAMX);
      default: begin
        if (addr < 16'hFE00)       idx = IDX_W'(R_WRAMX);
        else if (addr < 16'hFEA0)  idx = IDX_W'(R_OAM);
        else if (addr < 16'hFF00)  idx = IDX_W'(R_HOLE);
        else if (addr < 16'hFF80)  idx = IDX_W'(R_IO);
        else if (addr != 16'hFFFF) idx = IDX_W'(R_HRAM);
        else                       idx = IDX_W'(R_IE);
      end
    endcase
  end

  for (genvar g = 0; g < N_REG; g++) begin : g_sel
    assign sel[g] = (idx == IDX_W'(g));
  end

  always_comb begin
    off = '0;
    unique case (int'(idx))
      R_ROM0, R_ROMX: off = {2'b00, addr[13:0]};
      R_VRAM, R_XRAM: off = {3'b000, addr[12:0]};
      R_WRAM0:        off = {4'h0, addr[WBANK_SZ_LOG2-1:0]};
      R_WRAMX:        off = {{(ADDR_W-BANK_W-WBANK_SZ_LOG2){1'b0}}, bank,
                             addr[WBANK_SZ_LOG2-1:0]};
      R_OAM, R_HOLE:  off = {8'h00, addr[7:0]};
      R_IO, R_HRAM:   off = {9'h000, addr[6:0]};
      default:        off = '0;
    endcase
  end
endmodule

// File: rtl/memmap_access_gate.sv
module memmap_access_gate
  import memmap_pkg::*;
(
  input  logic [N_REG-1:0]        sel,
  input  logic                    wr,
  input  logic [1:0]              vmode,
  input  logic                    xram_en,
  input  logic [N_REG*DATA_W-1:0] lanes,
  output logic [DATA_W-1:0]       rdata,
  output logic                    tgt_wr,
  output logic                    cmd_wr
);
  logic [N_REG-1:0]  open;
  logic [DATA_W-1:0] lane_mux;
  logic [DATA_W-1:0] lane_and [N_REG];

  always_comb begin
    open          = '1;
    open[R_ROM0]  = 1'b0;
    open[R_ROMX]  = 1'b0;
    open[R_HOLE]  = 1'b0;
    open[R_VRAM]  = (vmode != 2'd3);
    open[R_OAM]   = (vmode < 2'd2);
    open[R_XRAM]  = xram_en;
  end

  for (genvar g = 0; g < N_REG; g++) begin : g_lane
    assign lane_and[g] = lanes[g*DATA_W +: DATA_W] & {DATA_W{sel[g]}};
  end

  always_comb begin
    lane_mux = '0;
    for (int i = 0; i < N_REG; i++) lane_mux |= lane_and[i];
  end

  logic rom_hit, readable;
  assign rom_hit  = sel[R_ROM0] | sel[R_ROMX];
  assign readable = rom_hit | |(sel & open);
  assign rdata    = readable ? lane_mux : OPEN_BUS;
  assign tgt_wr   = wr & |(sel & open);
  assign cmd_wr   = wr & rom_hit;
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic                    cpu_wr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  input  logic [1:0]              video_mode,
  input  logic                    xram_en,
  input  logic [N_REG*DATA_W-1:0] tgt_rdata,
  output logic [N_REG-1:0]        region_sel,
  output logic [ADDR_W-1:0]       phys_off,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    tgt_wr,
  output logic                    cart_cmd_wr,
  output logic [BANK_W-1:0]       wram_bank
);
  logic bank_load;
  assign bank_load = cpu_wr & (cpu_addr == BANK_REG_ADDR);

  memmap_bank_reg u_bank (
    .clk(clk), .rst_n(rst_n), .load(bank_load),
    .wdata(cpu_wdata), .bank(wram_bank)
  );

  memmap_region_dec u_dec (
    .addr(cpu_addr), .bank(wram_bank), .sel(region_sel), .off(phys_off)
  );

  memmap_access_gate u_gate (
    .sel(region_sel), .wr(cpu_wr), .vmode(video_mode), .xram_en(xram_en),
    .lanes(tgt_rdata), .rdata(cpu_rdata), .tgt_wr(tgt_wr),
    .cmd_wr(cart_cmd_wr)
  );
endmodule

// File: rtl/memmap_decoder_chk.sv
module memmap_decoder_chk
  import memmap_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       cpu_addr,
  input logic                    cpu_wr,
  input logic [DATA_W-1:0]       cpu_wdata,
  input logic [1:0]              video_mode,
  input logic                    xram_en,
  input logic [N_REG-1:0]        region_sel,
  input logic [DATA_W-1:0]       cpu_rdata,
  input logic                    tgt_wr,
  input logic                    cart_cmd_wr,
  input logic [BANK_W-1:0]       wram_bank
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(region_sel) == 1);

  a_r3_bank_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    wram_bank != '0);

  a_r3_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == BANK_REG_ADDR && cpu_wdata[2:0] != 3'd0)
      |=> wram_bank == $past(cpu_wdata[2:0]));

  a_r3_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr == BANK_REG_ADDR) |=> $stable(wram_bank));

  a_r4_vram_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (video_mode == 2'd3 && region_sel[R_VRAM]) |-> (cpu_rdata == 8'hFF && !tgt_wr));

  a_r5_oam_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (video_mode[1] && region_sel[R_OAM]) |-> (cpu_rdata == 8'hFF && !tgt_wr));

  a_r6_hole: assert property (@(posedge clk) disable iff (!rst_n)
    region_sel[R_HOLE] |-> (cpu_rdata == 8'hFF && !tgt_wr));

  a_r8_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_addr[15]) |-> (cart_cmd_wr && !tgt_wr));

  a_r9_xram_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!xram_en && region_sel[R_XRAM]) |-> (cpu_rdata == 8'hFF && !tgt_wr));
endmodule

bind memmap_decoder memmap_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .cpu_wdata(cpu_wdata), .video_mode(video_mode), .xram_en(xram_en),
  .region_sel(region_sel), .cpu_rdata(cpu_rdata), .tgt_wr(tgt_wr),
  .cart_cmd_wr(cart_cmd_wr), .wram_bank(wram_bank)
);

// File: tb/memmap_decoder_tb.sv
`timescale 1ns/100ps
module memmap_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [1:0]  video_mode = '0;
  logic        xram_en = 1'b0;
  logic [87:0] tgt_rdata = '0;
  logic [10:0] region_sel;
  logic [15:0] phys_off;
  logic [7:0]  cpu_rdata;
  logic        tgt_wr, cart_cmd_wr;
  logic [2:0]  wram_bank;

  int total = 0, bad = 0;
  logic [2:0] m_bank;

  always #2 clk = ~clk;

  memmap_decoder u_dut (.*);

  function automatic int ref_region(logic [15:0] a);
    if (a < 16'h4000) return 0;
    if (a < 16'h8000) return 1;
    if (a < 16'hA000) return 2;
    if (a < 16'hC000) return 3;
    if (a < 16'hD000) return 4;
    if (a < 16'hE000) return 5;
    if (a < 16'hF000) return 4;
    if (a < 16'hFE00) return 5;
    if (a < 16'hFEA0) return 6;
    if (a < 16'hFF00) return 7;
    if (a < 16'hFF80) return 8;
    if (a < 16'hFFFF) return 9;
    return 10;
  endfunction

  function automatic logic [15:0] ref_off(int r, logic [15:0] a, logic [2:0] b);
    case (r)
      0, 1:  return a & 16'h3FFF;
      2, 3:  return a & 16'h1FFF;
      4:     return a & 16'h0FFF;
      5:     return (16'(b) * 16'd4096) + (a & 16'h0FFF);
      6, 7:  return a & 16'h00FF;
      8, 9:  return a & 16'h007F;
      default: return 16'h0;
    endcase
  endfunction

  function automatic bit ref_open(int r, logic [1:0] vm, logic xe);
    case (r)
      0, 1, 7: return 1'b0;
      2:       return vm != 2'd3;
      3:       return xe;
      6:       return vm < 2'd2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string tag_of(int r);
    case (r)
      0, 1: return "R8";
      2:    return "R4";
      3:    return "R9";
      4, 5: return "R2";
      6:    return "R5";
      7:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%h act=%h exp=%h", tag, cpu_addr, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] a, logic w, logic [7:0] d,
                       logic [1:0] vm, logic xe);
    int r;
    logic [7:0] lane, exp_rd;
    bit op;
    @(negedge clk);
    cpu_addr = a; cpu_wr = w; cpu_wdata = d; video_mode = vm; xram_en = xe;
    tgt_rdata = {$urandom, $urandom, $urandom};
    #1;
    r    = ref_region(a);
    op   = ref_open(r, vm, xe);
    lane = tgt_rdata[r*8 +: 8];
    exp_rd = (op || r <= 1) ? lane : 8'hFF;
    chk("R1", 32'(region_sel), 32'(11'(1) << r));
    chk("R10", 32'(phys_off), 32'(ref_off(r, a, m_bank)));
    chk(op ? "R11" : tag_of(r), 32'(cpu_rdata), 32'(exp_rd));
    chk(op ? "R11" : tag_of(r), 32'(tgt_wr), 32'(w && op));
    chk("R8", 32'(cart_cmd_wr), 32'(w && r <= 1));
    chk("R3", 32'(wram_bank), 32'(m_bank));
    if (w && a == 16'hFF70) m_bank = (d[2:0] == 3'd0) ? 3'd1 : d[2:0];
  endtask

  initial begin
    void'($urandom(32'h5EED));
    #20000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] edges [26] = '{16'h0000, 16'h3FFF, 16'h4000, 16'h7FFF,
      16'h8000, 16'h9FFF, 16'hA000, 16'hBFFF, 16'hC000, 16'hCFFF, 16'hD000,
      16'hDFFF, 16'hE000, 16'hEFFF, 16'hF000, 16'hFDFF, 16'hFE00, 16'hFE9F,
      16'hFEA0, 16'hFEFF, 16'hFF00, 16'hFF7F, 16'hFF80, 16'hFFFE, 16'hFFFF,
      16'hD123};
    m_bank = 3'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3", 32'(wram_bank), 32'd1);             // reset value
    foreach (edges[i]) apply(edges[i], 1'b0, 8'h00, 2'd0, 1'b1);
    foreach (edges[i]) apply(edges[i], 1'b1, 8'h5A, 2'd3, 1'b0);
    apply(16'hFE10, 1'b1, 8'h11, 2'd2, 1'b1);     // R5 mode 2 locked
    apply(16'hFE10, 1'b1, 8'h11, 2'd1, 1'b1);     // R5 mode 1 open
    apply(16'h8100, 1'b1, 8'h11, 2'd2, 1'b1);     // R4 open in mode 2
    apply(16'hFF70, 1'b1, 8'h08, 2'd0, 1'b1);     // R3 zero becomes 1
    apply(16'hFF70, 1'b1, 8'hF6, 2'd0, 1'b1);     // R3 low bits 6
    apply(16'hD001, 1'b0, 8'h00, 2'd0, 1'b1);
    apply(16'hF7FF, 1'b0, 8'h00, 2'd0, 1'b1);
    apply(16'hFF71, 1'b1, 8'h03, 2'd0, 1'b1);     // R3 neighbour ignored
    apply(16'hD001, 1'b0, 8'h00, 2'd0, 1'b1);
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      a = (n % 4 == 0) ? 16'hFF70 : 16'($urandom);
      if (n % 7 == 0) a = 16'hFE00 | 16'($urandom_range(0, 255));
      apply(a, 1'($urandom), 8'($urandom), 2'($urandom), 1'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule